// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous SRAM Port

This block produces the word address presented to a synchronous SRAM array, cycle by cycle. A host loads a full external address by pulsing either of two independent address strobes. Both strobes are qualified by a select input. After the load, the host can pulse an advance input to step through a four-beat burst. Only the low two address bits change during the burst. The upper bits stay as loaded.

The stepping order is fixed for the whole run and is chosen by an order pin. The pin is captured while reset is held. In linear order the low bits count up by one and wrap at four. In interleaved order they equal the starting low bits XORed with the number of beats taken.

Bursts are optional. The host may load a new address on every cycle, and the output follows each load one clock later.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr_o` is all zeros, and the beat count is zero.
- R2: When `sel_i` is 1 and either `stb_a_i` or `stb_b_i` is 1 at a rising edge, `addr_o` equals `addr_i` from that edge onward. The burst restarts at beat 0.
- R3: A strobe with `sel_i` at 0 has no effect: the cycle behaves as if no strobe were present.
- R4: In linear order (order pin captured as 1), each advance without a load gives new low bits equal to the old low bits plus 1, modulo 4. For example, a start of 1 gives 1, 2, 3, 0.
- R5: In interleaved order (order pin captured as 0), the low bits after k advances equal the start low bits XOR (k mod 4). For example, a start of 1 gives 1, 0, 3, 2.
- R6: A cycle with neither a qualified strobe nor `adv_i` leaves `addr_o` unchanged.
- R7: A qualified strobe in the same cycle as `adv_i` loads `addr_i`; the advance is dropped.
- R8: Between loads, `addr_o` bits above bit 1 never change.
- R9: `order_lin_i` is sampled only while `rst_n` is low. Changing it after reset does not alter the sequence.
- R10: After four advances the low bits return to the loaded start value, and counting continues in the same order.
- R11: Qualified strobes on consecutive cycles load each address in turn, with no idle cycle between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; the order pin is captured while it is low |
| order_lin_i | input | 1 | 1 selects linear order, 0 selects interleaved order |
| sel_i | input | 1 | Qualifies both address strobes |
| stb_a_i | input | 1 | First address strobe |
| stb_b_i | input | 1 | Second address strobe |
| adv_i | input | 1 | Steps the burst by one beat |
| addr_i | input | ADDR_W | External address to load |
| addr_o | output | ADDR_W | Current array address |

## Verification
The assertions assume that the order pin needs to be stable only during reset. They also assume that the strobe, select and advance inputs are known, never X, whenever reset is released. The step assertions cover only cycles without a qualified strobe, because a load replaces the whole address.

The stimulus drives every input at the falling clock edge. It holds the order pin at its chosen value through reset and toggles it only afterwards, to exercise R9.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Low-bit value for a beat, in linear order (add, with wrap).
  function automatic logic [1:0] lo_linear(input logic [1:0] start, input logic [1:0] beat);
    return start + beat;
  endfunction

  // Low-bit value for a beat, in interleaved order (bitwise XOR).
  function automatic logic [1:0] lo_interleave(input logic [1:0] start, input logic [1:0] beat);
    return start ^ beat;
  endfunction

  // Picks the order.
  function automatic logic [1:0] lo_select(input logic [1:0] start, input logic [1:0] beat,
                                           input logic lin);
    return lin ? lo_linear(start, beat) : lo_interleave(start, beat);
  endfunction

endpackage

// File: rtl/burst_order_latch.sv
module burst_order_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic order_lin_i,
  output logic ord_lin_q
);
  // Transparent capture while reset is held; frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) ord_lin_q <= order_lin_i;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] beat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    beat_q <= '0;
    else if (load) beat_q <= '0;
    else if (step) beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= addr_i;
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_lin_i,
  input  logic              sel_i,
  input  logic              stb_a_i,
  input  logic              stb_b_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  import burst_pkg::*;

  localparam int HI_W = ADDR_W - CNT_W;

  // Named events for the checker.
  logic ld_evt;
  logic step_evt;
  logic ord_lin_q;
  logic [CNT_W-1:0]  beat_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  lo_w;

  assign ld_evt   = sel_i & (stb_a_i | stb_b_i);
  assign step_evt = adv_i & ~ld_evt;

  burst_order_latch u_ord (
    .clk(clk), .rst_n(rst_n), .order_lin_i(order_lin_i), .ord_lin_q(ord_lin_q)
  );

  burst_beat_ctr #(.CNT_W(CNT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .load(ld_evt), .step(step_evt), .beat_q(beat_q)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .load(ld_evt), .addr_i(addr_i), .base_q(base_q)
  );

  assign lo_w = lo_select(base_q[CNT_W-1:0], beat_q, ord_lin_q);

  generate
    if (HI_W > 0) begin : g_hi
      assign addr_o = {base_q[ADDR_W-1:CNT_W], lo_w};
    end else begin : g_lo_only
      assign addr_o = lo_w;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_evt,
  input logic              step_evt,
  input logic              ord_lin_q,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_evt |=> addr_o == $past(addr_i));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_evt && !step_evt) |=> $stable(addr_o));

  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_evt |=> $stable(addr_o[ADDR_W-1:CNT_W]));

  p_lin_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && ord_lin_q) |=>
      addr_o[CNT_W-1:0] == CNT_W'($past(addr_o[CNT_W-1:0]) + 1'b1));

  p_ilv_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !ord_lin_q) |=> addr_o[CNT_W-1:0] != $past(addr_o[CNT_W-1:0]));

  p_order_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ord_lin_q));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_evt(ld_evt), .step_evt(step_evt),
  .ord_lin_q(ord_lin_q), .addr_i(addr_i), .addr_o(addr_o)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic order_lin_i = 1;
  logic sel_i = 0, stb_a_i = 0, stb_b_i = 0, adv_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int errors = 0;

  // Model state
  int m_base = 0;
  int m_beat = 0;
  int m_lin  = 1;

  always #5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .order_lin_i(order_lin_i), .sel_i(sel_i),
    .stb_a_i(stb_a_i), .stb_b_i(stb_b_i), .adv_i(adv_i), .addr_i(addr_i), .addr_o(addr_o)
  );

  function automatic int exp_addr();
    int s = m_base % 4;
    int lo = m_lin ? (s + m_beat) % 4 : (s ^ m_beat);
    return (m_base / 4) * 4 + lo;
  endfunction

  task automatic check(input string tag, input int exp);
    checks++;
    if (int'(addr_o) != exp) begin
      errors++;
      $display("FAIL %s: addr_o=%0d expected=%0d", tag, addr_o, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic s, input logic a, input logic b,
                     input logic v, input int ad);
    sel_i = s; stb_a_i = a; stb_b_i = b; adv_i = v; addr_i = AW'(ad);
    @(negedge clk);
    if (s && (a || b)) begin m_base = ad % (1 << AW); m_beat = 0; end
    else if (v) m_beat = (m_beat + 1) % 4;
    check(tag, exp_addr());
  endtask

  task automatic do_reset(input int lin);
    rst_n = 0; order_lin_i = lin[0];
    sel_i = 0; stb_a_i = 0; stb_b_i = 0; adv_i = 0; addr_i = '0;
    repeat (3) @(negedge clk);
    m_base = 0; m_beat = 0; m_lin = lin;
    check("R1", 0);
    rst_n = 1;
  endtask

  task automatic run_mode(input int lin);
    string stag;
    stag = (lin != 0) ? "R4" : "R5";
    do_reset(lin);
    // Sweep both strobes and all start values.
    for (int st = 0; st < 2; st++) begin
      for (int s0 = 0; s0 < 4; s0++) begin
        int ad = (37 * (s0 + 4 * st) + 200) % 1024;
        ad = (ad / 4) * 4 + s0;
        cyc("R2", 1, st == 0, st == 1, 0, ad);
        for (int k = 0; k < 3; k++) cyc(stag, 0, 0, 0, 1, 0);
        cyc("R10", 0, 0, 0, 1, 0);       // fourth advance: back to start
        cyc("R6", 0, 0, 0, 0, 5);        // hold
        cyc("R8", 0, 0, 0, 1, 999);      // upper bits fixed, continues order
      end
    end
    // Strobe beats advance.
    cyc("R7", 1, 1, 0, 1, 514);
    cyc(stag, 0, 0, 0, 1, 0);
    cyc("R7", 1, 0, 1, 1, 771);
    // Unqualified strobe ignored, with and without advance.
    cyc("R3", 0, 1, 1, 0, 33);
    cyc("R3", 0, 1, 0, 1, 66);
    cyc("R3", 0, 0, 1, 1, 99);
    // Back-to-back loads.
    for (int i = 0; i < 8; i++) cyc("R11", 1, i[0], ~i[0], 0, 128 * i + 3 * i + 1);
    // Order pin changed after reset: no effect.
    order_lin_i = ~order_lin_i;
    cyc("R9", 1, 1, 0, 0, 401);
    for (int k = 0; k < 4; k++) cyc("R9", 0, 0, 0, 1, 0);
    order_lin_i = lin[0];
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    run_mode(1);
    run_mode(0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule